// File: doc/BRIEF.md
# Iterative Half-Adder Completion Adder

This block adds two unsigned N-bit operands without a carry chain. A single row of half adders is fed either by the operands or by its own registered sum and carry vectors. The first half-addition on the operands happens on the clock edge that accepts a request. After that, the row half-adds the previous partial sum with the carry vector shifted up by one bit, once per clock. It stops when the carry vector is entirely zero, and then flags completion for one cycle.

The number of cycles depends on the data. Operands with no overlapping set bits finish at once. The longest case is a carry that must walk the full width. A carry pushed off the top bit is caught in a sticky register, which supplies the carry-out. A request that arrives while an operation is running is ignored. The result stays on the outputs until the next accepted request.

Latency L below counts clock edges. The accepting edge counts as 1. L is the edge after which `done` reads high.

Top module: `hcr_adder`

## Requirements
- R1: While reset is asserted and after its release, `sum` is 0, `cout` is 0 and `done` is 0.
- R2: A high `req` seen on a rising edge while no operation is running starts an operation on the `a` and `b` values present at that edge.
- R3: In the cycle where `done` is high, `{cout, sum}` equals the (W+1)-bit sum of the accepted `a` and `b`.
- R4: Each accepted operation raises `done` exactly once, for one cycle, with latency L no greater than W.
- R5: When the accepted operands share no set bit (`a & b == 0`), L is 1.
- R6: Operands all-ones and 1 give the longest ripple: L equals W, with `sum` 0 and `cout` 1.
- R7: A high `req` during a running operation, including its `done` cycle, is ignored. It produces no extra `done`, and the outputs keep the first operation's result.
- R8: Outside a running operation, `sum` and `cout` keep their last result until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, sampled on rising edges when idle |
| a | input | W | First operand |
| b | input | W | Second operand |
| sum | output | W | Low W bits of the result; partial during an operation |
| cout | output | 1 | Carry out of the top bit (sticky during an operation) |
| done | output | 1 | One-cycle completion flag |

## Verification
The assertions check on every cycle that:
- the feedback select only rises after a request;
- the iteration count never exceeds W;
- `done` is a single-cycle pulse that always returns the block to idle, even with `req` held high;
- a request with non-overlapping operands completes on the next cycle;
- the outputs stay still while idle and after completion.

Only the bench's scenarios can show two things: that the final value is the true sum, and the exact latencies of the long-ripple case. The bench shows these over directed and random operands, and with a request held high across a whole operation.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic {
    HCR_IDLE = 1'b0,
    HCR_RUN  = 1'b1
  } hcr_state_e;
endpackage

// File: rtl/hcr_opsel.sv
// Per-bit 2:1 select: external operands while idle, registered feedback while running.
module hcr_opsel #(
  parameter int W = 16
) (
  input  logic         sel,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] fb_sum,
  input  logic [W-1:0] fb_carry,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x[i] = sel ? fb_sum[i]   : op_a[i];
    assign y[i] = sel ? fb_carry[i] : op_b[i];
  end
endmodule

// File: rtl/hcr_ha_row.sv
// Row of independent half adders; no carry passes between bits here.
module hcr_ha_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] hs,
  output logic [W-1:0] hc
);
  function automatic logic half_sum(input logic p, input logic q);
    return p ^ q;
  endfunction

  function automatic logic half_carry(input logic p, input logic q);
    return p & q;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_ha
    assign hs[i] = half_sum(x[i], y[i]);
    assign hc[i] = half_carry(x[i], y[i]);
  end
endmodule

// File: rtl/hcr_ctrl.sv
// Sequencer: idle/run state, feedback select, step and completion strobes.
module hcr_ctrl
  import hcr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic carry_zero,
  output logic sel,
  output logic accept,
  output logic step,
  output logic done
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] ITER_MAX = CW'(W);

  hcr_state_e    state_q;
  logic [CW-1:0] iter_q;

  assign sel    = (state_q == HCR_RUN);
  assign accept = !sel && req;
  assign step   = sel && !carry_zero;
  assign done   = sel && carry_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HCR_IDLE;
      iter_q  <= '0;
    end else begin
      case (state_q)
        HCR_IDLE: if (req) begin
          state_q <= HCR_RUN;
          iter_q  <= CW'(1);
        end
        HCR_RUN: begin
          if (carry_zero) state_q <= HCR_IDLE;
          else            iter_q  <= iter_q + CW'(1);
        end
        default: state_q <= HCR_IDLE;
      endcase
    end
  end

  // R2: feedback select only rises after a request edge
  p_sel_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(req));

  // R4: iteration count bounded by the operand width
  p_iter_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (iter_q <= ITER_MAX));

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: completion always returns to idle, whatever req does
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sel);
endmodule

// File: rtl/hcr_adder.sv
// Iterative half-adder adder: half-add until the shifted carry vector is empty.
module hcr_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         done
);
  logic [W-1:0] s_q, c_q;
  logic         cout_q;
  logic [W-1:0] x, y, hs, hc, c_next;
  logic         sel, accept, step, carry_zero;

  assign carry_zero = (c_q == '0);
  assign c_next     = {hc[W-2:0], 1'b0};

  hcr_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .carry_zero (carry_zero),
    .sel        (sel),
    .accept     (accept),
    .step       (step),
    .done       (done)
  );

  hcr_opsel #(.W(W)) u_sel (
    .sel      (sel),
    .op_a     (a),
    .op_b     (b),
    .fb_sum   (s_q),
    .fb_carry (c_q),
    .x        (x),
    .y        (y)
  );

  hcr_ha_row #(.W(W)) u_row (
    .x  (x),
    .y  (y),
    .hs (hs),
    .hc (hc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= '0;
      c_q    <= '0;
      cout_q <= 1'b0;
    end else if (accept) begin
      s_q    <= hs;
      c_q    <= c_next;
      cout_q <= hc[W-1];
    end else if (step) begin
      s_q    <= hs;
      c_q    <= c_next;
      cout_q <= cout_q | hc[W-1];
    end
  end

  assign sum  = s_q;
  assign cout = cout_q;

  // R5: non-overlapping operands finish right after acceptance
  p_zero_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && req && ((a & b) == '0)) |=> done);

  // R8: outputs hold while idle without a request
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !req) |=> ($stable(sum) && $stable(cout)));

  // R8: outputs hold across the edge that ends an operation
  p_hold_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(sum) && $stable(cout)));

  // R3: top carry, once captured, is kept for the rest of the operation
  p_cout_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cout) |=> cout);
endmodule

// File: tb/sim_hcr_adder.sv
module sim_hcr_adder;
  localparam int W = 16;
  localparam int CLK_PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum;
  logic         cout, done;

  int total = 0;
  int bad = 0;

  // behavioural reference model state
  bit           m_busy = 0;
  bit           m_seen = 0;
  int           m_lat = 0;
  int           last_lat = 0;
  logic [W:0]   m_exp = '0;
  logic [W:0]   m_last = '0;

  always #(CLK_PER/2) clk = ~clk;

  hcr_adder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .a(a), .b(b),
    .sum(sum), .cout(cout), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // model update at the clock edge (inputs were driven away from it)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_seen = 0; m_lat = 0; m_last = '0;
    end else if (m_busy && m_seen) begin
      m_busy = 0; m_seen = 0;           // R7: req in the done cycle is dropped
    end else if (!m_busy && req) begin
      m_busy = 1; m_lat = 1;            // R2
      m_exp = {1'b0, a} + {1'b0, b};
    end else if (m_busy) begin
      m_lat++;
    end
  end

  // comparison every cycle, at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_busy && !m_seen) begin
        if (done) begin
          chk({cout, sum} == m_exp, "R3 result", {cout, sum}, m_exp);
          chk(m_lat <= W, "R4 latency bound", m_lat, W);
          last_lat = m_lat;
          m_last = m_exp;
          m_seen = 1;
        end else if (m_lat > W) begin
          chk(0, "R4 no done in time", m_lat, W);
        end
      end else begin
        chk(done == 1'b0, "R4/R7 stray done", done, 0);
        chk({cout, sum} == m_last, "R8 hold", {cout, sum}, m_last);
      end
    end
  end

  task automatic run_op(input logic [W-1:0] va, input logic [W-1:0] vb, output int lat);
    bit seen;
    seen = 0;
    @(negedge clk); #1;
    a = va; b = vb; req = 1'b1;
    @(negedge clk); #1;
    req = 1'b0;
    for (int k = 0; k < W + 3; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk); #1;
    end
    chk(seen, "R4 done seen", seen, 1);
    lat = last_lat;
  endtask

  initial begin
    #(CLK_PER * 200000);
    bad++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk({cout, sum, done} == '0, "R1 in reset", {cout, sum, done}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk({cout, sum, done} == '0, "R1 after reset", {cout, sum, done}, 0);

    // R5: disjoint bits
    run_op(16'h00F0, 16'h0F0F, lat);
    chk(lat == 1, "R5 disjoint latency", lat, 1);
    chk({cout, sum} == 17'h00FFF, "R5 disjoint sum", {cout, sum}, 17'h00FFF);
    run_op(16'h0000, 16'h0000, lat);
    chk(lat == 1, "R5 zero latency", lat, 1);

    // R6: longest ripple
    run_op(16'hFFFF, 16'h0001, lat);
    chk(lat == W, "R6 ripple latency", lat, W);
    chk({cout, sum} == 17'h10000, "R6 ripple result", {cout, sum}, 17'h10000);

    // R3: assorted carry patterns
    run_op(16'hFFFF, 16'hFFFF, lat);
    chk({cout, sum} == 17'h1FFFE, "R3 all ones", {cout, sum}, 17'h1FFFE);
    run_op(16'h8000, 16'h8000, lat);
    chk({cout, sum} == 17'h10000, "R3 top carry only", {cout, sum}, 17'h10000);
    run_op(16'h0001, 16'h0001, lat);
    chk(lat == 2, "R3 single carry latency", lat, 2);

    // R8: idle hold
    repeat (5) @(negedge clk);
    #1;
    chk({cout, sum} == 17'h00002, "R8 idle hold", {cout, sum}, 17'h00002);

    // R7: req held through an operation and its done cycle
    @(negedge clk); #1;
    a = 16'hFFFF; b = 16'h0001; req = 1'b1;
    @(negedge clk); #1;
    a = 16'h1234; b = 16'h4321;
    for (int k = 0; k < W + 3; k++) begin
      if (done) break;
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    req = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk({cout, sum} == 17'h10000, "R7 ignored request", {cout, sum}, 17'h10000);
    chk(done == 1'b0, "R7 no extra done", done, 0);

    // random patterns
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      case (n % 4)
        1: rb = ~ra ^ W'(1 << (n % W));
        2: begin ra = '1; rb = W'($urandom_range(0, 7)); end
        3: begin ra = ra & W'($urandom); rb = rb & W'($urandom); end
        default: ;
      endcase
      run_op(ra, rb, lat);
      chk(lat <= W, "R4 random bound", lat, W);
      if (n % 7 == 0) repeat (2) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule